// File: doc/BRIEF.md
# SDRAM Mode Word Decoder and Column Burst Sequencer

This block holds the operating mode of a synchronous DRAM controller and turns each access command into a stream of column addresses. When the mode-set strobe is high, the 12-bit address word is split into its fields and checked. A legal word replaces the stored mode. An illegal word is dropped and flagged. The stored mode gives the write policy, the CAS latency, the address ordering and the burst length.

When a read or write strobe arrives, the sequencer registers the start column and then presents one column address per clock. A valid flag covers the whole burst, and a last flag marks its final beat. The decoded CAS latency is driven out continuously, so that a later data-timing stage can line up the data phase. The full-page length is set at build time from the device organisation: 512 columns for the 8-bit part and 1024 for the 4-bit part.

Top module: `sdram_mode_seq`

## Requirements
- R1: During and after reset the stored mode is: burst length 1, sequential order, CAS latency 2, burst write. `cas_lat_o` reads 2, and `col_vld_o`, `last_o` and `mode_err_o` are low.
- R2: When `mrs_i` is high, `addr_i` is decoded as follows:
  - bits [11:8]: write policy, where 0000 is burst write and 0010 is single write;
  - bit [7]: must be 0;
  - bits [6:4]: CAS latency, where codes 1, 2 and 3 give latencies 1, 2 and 3;
  - bit [3]: order, where 0 is sequential and 1 is interleaved;
  - bits [2:0]: length, where 000, 001, 010 and 011 give 1, 2, 4 and 8 beats and 111 gives a full page.

  A legal word is stored at that edge, and `cas_lat_o` shows the new latency from the next cycle.
- R3: A mode word with a reserved write-policy code, bit 7 set, a reserved CAS code or a reserved length code raises `mode_err_o` for exactly the cycle after the strobe. It leaves the stored mode unchanged.
- R4: Full-page length combined with interleaved order is rejected as in R3.
- R5: A read or write strobe puts beat 0 on `col_o` in the cycle after the strobe. One new column follows per cycle, and `col_vld_o` stays high for exactly the burst length.
- R6: In sequential order, beat i is the start column with its low log2(L) bits replaced by (start + i) mod L. The burst wraps inside the aligned block of L columns.
- R7: In interleaved order, beat i is the start column XOR i.
- R8: A full-page burst lasts FULL_PAGE_COLS beats and wraps from the top column to column 0.
- R9: In single-write mode a write yields one beat at the start column, while reads still run the programmed length.
- R10: `last_o` is high only in the cycle that carries the final column of a burst.
- R11: A new read or write strobe during a burst ends the old burst. The new burst's beat 0 appears in the next cycle.
- R12: If `mrs_i` is high together with `rd_i` or `wr_i`, the mode set takes effect and the access is ignored. When both `rd_i` and `wr_i` are high, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mrs_i | input | 1 | Mode-set strobe |
| rd_i | input | 1 | Read command strobe |
| wr_i | input | 1 | Write command strobe |
| addr_i | input | 12 | Mode word, sampled with `mrs_i` |
| col_i | input | COL_W | Start column, sampled with `rd_i` or `wr_i` |
| col_o | output | COL_W | Current burst column |
| col_vld_o | output | 1 | `col_o` holds a burst beat |
| last_o | output | 1 | Final beat of the burst |
| mode_err_o | output | 1 | Last mode word was rejected |
| cas_lat_o | output | 2 | Stored CAS latency (1 to 3) |

## Verification
The bench builds the block with FULL_PAGE_COLS set to 64 instead of 512. A complete full-page burst, including its wrap from column 63 back to 0, then takes only 64 cycles. That leaves room to run every length and both orders from start columns that are not aligned. The stimulus also covers each reserved encoding, a single write followed by a read, an interrupted burst, and a mode set issued together with a command.

// File: rtl/sdram_mode_pkg.sv
// Shared types for the mode decoder and burst sequencer.
// Assumes a 12-bit mode word with fixed field positions.
package sdram_mode_pkg;

    localparam int MODE_W = 12;

    typedef enum logic [2:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_PAGE = 3'd7
    } blen_e;

    typedef struct packed {
        logic        single_wr;
        logic [1:0]  cas_lat;
        logic        interleave;
        blen_e       blen;
    } mode_t;

    localparam mode_t MODE_RESET = '{
        single_wr:  1'b0,
        cas_lat:    2'd2,
        interleave: 1'b0,
        blen:       BLEN_1
    };

endpackage

// File: rtl/sdram_mode_decode.sv
// Splits a raw mode word into fields and reports whether every field uses
// a permitted code. Purely combinational; the fields are only meaningful
// when legal_o is high.
module sdram_mode_decode
    import sdram_mode_pkg::*;
(
    input  logic [MODE_W-1:0] word_i,
    output mode_t             mode_o,
    output logic              legal_o
);

    logic [3:0] wr_code;
    logic [2:0] cl_code;
    logic [2:0] bl_code;
    logic       wr_ok, cl_ok, bl_ok, rsv_ok;

    // Field extraction and per-field legality
    always_comb begin
        wr_code = word_i[11:8];
        cl_code = word_i[6:4];
        bl_code = word_i[2:0];
        wr_ok   = (wr_code == 4'b0000) || (wr_code == 4'b0010);
        rsv_ok  = ~word_i[7];
        cl_ok   = (cl_code == 3'd1) || (cl_code == 3'd2) || (cl_code == 3'd3);
        bl_ok   = (bl_code <= 3'd3) || ((bl_code == 3'd7) && ~word_i[3]);
        legal_o = wr_ok & rsv_ok & cl_ok & bl_ok;
    end

    // Decoded mode fields
    always_comb begin
        mode_o.single_wr  = wr_code[1];
        mode_o.cas_lat    = cl_code[1:0];
        mode_o.interleave = word_i[3];
        mode_o.blen       = blen_e'(bl_code);
    end

endmodule

// File: rtl/sdram_mode_store.sv
// Holds the active mode. A legal word replaces it on a mode-set strobe; an
// illegal one is dropped and produces a one-cycle error pulse.
module sdram_mode_store
    import sdram_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mrs_i,
    input  logic  legal_i,
    input  mode_t mode_i,
    output mode_t mode_o,
    output logic  err_o
);

    // Mode register update with synchronous reset to the default mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= MODE_RESET;
        end else if (mrs_i && legal_i) begin
            mode_o <= mode_i;
        end
    end

    // Error pulse for a rejected mode word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else begin
            err_o <= mrs_i & ~legal_i;
        end
    end

endmodule

// File: rtl/sdram_burst_gen.sv
// Generates one column address per cycle for an accepted command.
// Assumes COL_W >= 3 and a power-of-two page. A new command replaces any
// burst in flight.
module sdram_burst_gen
    import sdram_mode_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             is_wr_i,
    input  logic [COL_W-1:0] col_i,
    input  mode_t            mode_i,
    output logic [COL_W-1:0] col_o,
    output logic             vld_o,
    output logic             last_o
);

    localparam logic [COL_W-1:0] IDX_PAGE = '1;

    logic [COL_W-1:0] len_mask;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic             act_q;
    logic             at_end;

    // Final beat index (burst length - 1) for the command being accepted
    always_comb begin
        unique case (mode_i.blen)
            BLEN_1:    len_mask = '0;
            BLEN_2:    len_mask = COL_W'(1);
            BLEN_4:    len_mask = COL_W'(3);
            BLEN_8:    len_mask = COL_W'(7);
            BLEN_PAGE: len_mask = IDX_PAGE;
            default:   len_mask = '0;
        endcase
        if (is_wr_i && mode_i.single_wr) begin
            len_mask = '0;
        end
    end

    assign at_end = (idx_q == mask_q);

    // Burst state: start, beat counter and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
        end else if (start_i) begin
            act_q  <= 1'b1;
            idx_q  <= '0;
            base_q <= col_i;
            mask_q <= len_mask;
            ilv_q  <= mode_i.interleave;
        end else if (act_q) begin
            if (at_end) begin
                act_q <= 1'b0;
            end else begin
                idx_q <= idx_q + COL_W'(1);
            end
        end
    end

    // Column for the current beat in the selected order
    always_comb begin
        if (ilv_q) begin
            col_o = base_q ^ idx_q;
        end else begin
            col_o = (base_q & ~mask_q) | ((base_q + idx_q) & mask_q);
        end
    end

    assign vld_o  = act_q;
    assign last_o = act_q & at_end;

endmodule

// File: rtl/sdram_mode_seq.sv
// Top level: mode word capture and column burst sequencing.
// A mode-set strobe takes priority over an access in the same cycle, and a
// write takes priority over a read. FULL_PAGE_COLS must be a power of two
// and at least 8.
module sdram_mode_seq
    import sdram_mode_pkg::*;
#(
    parameter int FULL_PAGE_COLS = 512,
    localparam int COL_W = $clog2(FULL_PAGE_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [MODE_W-1:0] addr_i,
    input  logic [COL_W-1:0]  col_i,
    output logic [COL_W-1:0]  col_o,
    output logic              col_vld_o,
    output logic              last_o,
    output logic              mode_err_o,
    output logic [1:0]        cas_lat_o
);

    mode_t dec_mode;
    mode_t cur_mode;
    logic  dec_legal;
    logic  cmd_go;

    // Access accepted only when no mode set is pending
    assign cmd_go = (rd_i | wr_i) & ~mrs_i;

    sdram_mode_decode u_dec (
        .word_i  (addr_i),
        .mode_o  (dec_mode),
        .legal_o (dec_legal)
    );

    sdram_mode_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .mrs_i   (mrs_i),
        .legal_i (dec_legal),
        .mode_i  (dec_mode),
        .mode_o  (cur_mode),
        .err_o   (mode_err_o)
    );

    sdram_burst_gen #(.COL_W(COL_W)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (cmd_go),
        .is_wr_i (wr_i),
        .col_i   (col_i),
        .mode_i  (cur_mode),
        .col_o   (col_o),
        .vld_o   (col_vld_o),
        .last_o  (last_o)
    );

    assign cas_lat_o = cur_mode.cas_lat;

endmodule

// File: rtl/sdram_mode_seq_chk.sv
// Protocol checks on the top-level ports, bound into every instance.
module sdram_mode_seq_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mrs_i,
    input logic             rd_i,
    input logic             wr_i,
    input logic [COL_W-1:0] col_o,
    input logic             col_vld_o,
    input logic             last_o,
    input logic             mode_err_o,
    input logic [1:0]       cas_lat_o
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!col_vld_o && !mode_err_o && cas_lat_o == 2'd2));

    // R2
    cas_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_lat_o != 2'd0);

    // R3
    err_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> $stable(cas_lat_o));

    // R3
    err_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> $past(mrs_i));

    // R5
    cmd_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_i || wr_i) && !mrs_i) |=> col_vld_o);

    // R5
    burst_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld_o && !last_o && !((rd_i || wr_i) && !mrs_i)) |=> col_vld_o);

    // R6
    beat_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld_o && !last_o && !((rd_i || wr_i) && !mrs_i)) |=> col_o != $past(col_o));

    // R10
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> col_vld_o);

    // R10
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !((rd_i || wr_i) && !mrs_i)) |=> !col_vld_o);

endmodule

bind sdram_mode_seq sdram_mode_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mrs_i      (mrs_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .col_o      (col_o),
    .col_vld_o  (col_vld_o),
    .last_o     (last_o),
    .mode_err_o (mode_err_o),
    .cas_lat_o  (cas_lat_o)
);

// File: tb/sdram_mode_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_mode_seq_tb_top;

    localparam int PAGE  = 64;
    localparam int COL_W = $clog2(PAGE);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mrs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [11:0]      addr = '0;
    logic [COL_W-1:0] col_in = '0;
    logic [COL_W-1:0] col_o;
    logic             col_vld_o, last_o, mode_err_o;
    logic [1:0]       cas_lat_o;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // reference model state
    int m_sw = 0, m_cl = 2, m_ilv = 0, m_len = 1;
    int exp_err = 0;
    int q[$];

    always #2.5 clk = ~clk;

    sdram_mode_seq #(.FULL_PAGE_COLS(PAGE)) dut_i (
        .clk(clk), .rst_n(rst_n), .mrs_i(mrs), .rd_i(rd), .wr_i(wr),
        .addr_i(addr), .col_i(col_in), .col_o(col_o), .col_vld_o(col_vld_o),
        .last_o(last_o), .mode_err_o(mode_err_o), .cas_lat_o(cas_lat_o)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int word_ok(input logic [11:0] w);
        int cl = int'(w[6:4]);
        int bl = int'(w[2:0]);
        if (w[11:8] != 4'h0 && w[11:8] != 4'h2) return 0;
        if (w[7]) return 0;
        if (cl < 1 || cl > 3) return 0;
        if (bl == 7) return (w[3] == 1'b0) ? 1 : 0;
        return (bl <= 3) ? 1 : 0;
    endfunction

    task automatic compare();
        chk("valid", int'(col_vld_o), (q.size() > 0) ? 1 : 0);
        if (q.size() > 0) begin
            chk("column", int'(col_o), q[0]);
            chk("last", int'(last_o), (q.size() == 1) ? 1 : 0);
        end
        chk("mode_err", int'(mode_err_o), exp_err);
        chk("cas_lat", int'(cas_lat_o), m_cl);
    endtask

    // one clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic cyc(input bit m, input bit r, input bit w, input logic [11:0] a, input int c);
        mrs = m; rd = r; wr = w; addr = a; col_in = COL_W'(c);
        @(posedge clk);
        if (q.size() > 0) void'(q.pop_front());
        exp_err = (m && word_ok(a) == 0) ? 1 : 0;
        if (m) begin
            if (word_ok(a) != 0) begin
                m_sw  = (a[9] == 1'b1) ? 1 : 0;
                m_cl  = int'(a[6:4]);
                m_ilv = int'(a[3]);
                m_len = (a[2:0] == 3'd7) ? PAGE : (1 << int'(a[2:0]));
            end
        end else if (r || w) begin
            int len = (w && m_sw != 0) ? 1 : m_len;
            q.delete();
            for (int i = 0; i < len; i++) begin
                if (m_ilv != 0) q.push_back(c ^ i);
                else q.push_back((c - (c % len)) + ((c % len) + i) % len);
            end
        end
        @(negedge clk);
        compare();
        mrs = 0; rd = 0; wr = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 12'h0, 0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1'b1;
        idle(2);
        tag = "R1";
        cyc(0, 1, 0, 12'h0, 5); idle(2);

        // R2, R6: BL4 sequential CL3, unaligned start
        tag = "R6";
        cyc(1, 0, 0, 12'h032, 0);
        cyc(0, 1, 0, 12'h0, 6); idle(5);
        // R5: BL2 CL1
        tag = "R5";
        cyc(1, 0, 0, 12'h011, 0);
        cyc(0, 1, 0, 12'h0, 9); idle(3);

        // R7: BL8 interleaved CL1
        tag = "R7";
        cyc(1, 0, 0, 12'h01B, 0);
        cyc(0, 1, 0, 12'h0, 13); idle(9);
        cyc(0, 0, 1, 12'h0, 42); idle(9);

        // R9: single write, BL8 sequential CL2
        tag = "R9";
        cyc(1, 0, 0, 12'h223, 0);
        cyc(0, 0, 1, 12'h0, 3); idle(2);
        cyc(0, 1, 0, 12'h0, 3); idle(9);

        // R8, R10: full page sequential, wrap at top
        tag = "R8";
        cyc(1, 0, 0, 12'h027, 0);
        cyc(0, 1, 0, 12'h0, 60); idle(PAGE + 2);

        // R4: full page with interleave rejected
        tag = "R4";
        cyc(1, 0, 0, 12'h03F, 0); idle(1);
        // R3: other reserved codes, mode kept
        tag = "R3";
        cyc(1, 0, 0, 12'h133, 0);
        cyc(1, 0, 0, 12'h0B3, 0);
        cyc(1, 0, 0, 12'h003, 0);
        cyc(1, 0, 0, 12'h043, 0);
        cyc(1, 0, 0, 12'h034, 0);
        cyc(1, 0, 0, 12'h835, 0);
        cyc(0, 0, 1, 12'h0, 17); idle(PAGE + 2);

        // R11: interrupt a BL8 burst
        tag = "R11";
        cyc(1, 0, 0, 12'h013, 0);
        cyc(0, 1, 0, 12'h0, 20); idle(2);
        cyc(0, 1, 0, 12'h0, 35); idle(9);

        // R12: mode set with access in same cycle, and read+write together
        tag = "R12";
        cyc(1, 1, 0, 12'h021, 4); idle(2);
        cyc(1, 0, 0, 12'h202, 0);
        cyc(0, 1, 1, 12'h0, 7); idle(2);
        cyc(0, 1, 0, 12'h0, 7); idle(5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule